// File: doc/BRIEF.md
# Four-State Debug Trigger Sequencer

This block watches a vector of complex trigger events and recognises a programmed ordering of them. It is a small machine with four states, numbered 0 to 3. State 0 is the idle state and state 3 is the final state. Each state holds two settings. The first is the index of the one trigger input that moves the machine out of that state. The second is the state the machine moves to when that trigger fires. With these settings, a chain of three different triggers can be built, for example to react to the last byte of a three-byte command. The same settings also allow a jump straight to the final state, or a move back to an earlier state.

When the machine first enters state 3, it emits a one-cycle halt request, a one-cycle storage request, or both. Two action enables choose which. The machine then stays in state 3 until it is re-armed. A re-arm pulse, or any configuration write, returns it to state 0. The trigger vector is sampled once per clock as a level and has no handshake. The configuration and action pins are plain strobes.

Top module: `dbg_trig_seq`

## Requirements
- R1: During and after reset, `seq_state` is 0 and both request outputs are low. The configuration resets so that every state selects trigger index 0, states 0, 1 and 2 advance to states 1, 2 and 3, halt is enabled and storage is disabled.
- R2: In states 0 to 2, if the selected trigger bit is 1 at a rising edge, `seq_state` takes the programmed next state at that edge. If the bit is 0, the state does not change.
- R3: Trigger bits other than the one selected for the current state have no effect on `seq_state`.
- R4: At most one transition happens per clock, even when every trigger bit is high.
- R5: On the edge that enters state 3 from another state, `halt_req` goes high for exactly one cycle if halt is enabled, and stays low otherwise.
- R6: On that same entry, `store_req` goes high for exactly one cycle if storage is enabled. The two enables act independently of each other.
- R7: In state 3 the triggers are ignored. The state stays 3 and no further request pulses appear until a re-arm or a configuration write.
- R8: When `rearm` is 1 at an edge, `seq_state` becomes 0 at that edge and no request pulse is produced. This takes priority over any trigger.
- R9: A state-entry write sets the selector of state `cfg_state` to `cfg_sel` and its next state to `cfg_next`. An action write sets the two enables. Either write returns the machine to state 0, and the new values apply from the following cycle.
- R10: The next-state field may name any state, so the machine can skip forward (for example 0 to 3) or move backward (for example 1 to 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| trig_in | input | NUM_TRIG | Complex trigger events, one bit per trigger |
| rearm | input | 1 | Return to state 0 |
| cfg_we | input | 1 | Strobe for a state-entry write |
| cfg_state | input | 2 | State whose entry is written |
| cfg_sel | input | SEL_W | Trigger index for that state |
| cfg_next | input | 2 | Next state for that state |
| act_we | input | 1 | Strobe for an action-enable write |
| act_halt_en | input | 1 | Halt-on-final enable value |
| act_store_en | input | 1 | Store-on-final enable value |
| halt_req | output | 1 | One-cycle halt request on entry to state 3 |
| store_req | output | 1 | One-cycle storage request on entry to state 3 |
| seq_state | output | 2 | Current state |

## Verification
The bench builds the block with NUM_TRIG = 8. At that width the 3-bit selector field is fully used, so trigger indices from 0 up to 7 can be selected. A reference model in the bench predicts the state and both pulses for every cycle.

The stimulus covers:
- a forward chain using three different triggers;
- a direct skip to the final state;
- a backward loop;
- all-ones trigger vectors, which test the one-step-per-clock rule;
- re-arms and configuration writes made while the sequencer is in the middle of a sequence.

// File: rtl/dbg_trig_seq_pkg.sv
package dbg_trig_seq_pkg;
  localparam int unsigned NUM_STATES = 4;
  localparam int unsigned ST_W       = $clog2(NUM_STATES);

  typedef logic [ST_W-1:0] seq_st_t;

  localparam seq_st_t ST_IDLE  = seq_st_t'(0);
  localparam seq_st_t ST_FINAL = seq_st_t'(NUM_STATES - 1);
endpackage

// File: rtl/dbg_trig_seq_cfg.sv
module dbg_trig_seq_cfg
  import dbg_trig_seq_pkg::*;
#(
  parameter int unsigned SEL_W = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  seq_st_t                     cfg_state,
  input  logic [SEL_W-1:0]            cfg_sel,
  input  seq_st_t                     cfg_next,
  input  logic                        act_we,
  input  logic                        act_halt_en,
  input  logic                        act_store_en,
  output logic [NUM_STATES*SEL_W-1:0] sel_flat,
  output logic [NUM_STATES*ST_W-1:0]  next_flat,
  output logic                        halt_en,
  output logic                        store_en
);

  for (genvar s = 0; s < NUM_STATES; s++) begin : g_entry
    localparam seq_st_t DEF_NEXT = (s == NUM_STATES - 1) ? ST_FINAL : seq_st_t'(s + 1);

    logic [SEL_W-1:0] sel_q;
    seq_st_t          next_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sel_q  <= '0;
        next_q <= DEF_NEXT;
      end else if (cfg_we && (cfg_state == seq_st_t'(s))) begin
        sel_q  <= cfg_sel;
        next_q <= cfg_next;
      end
    end

    assign sel_flat[s*SEL_W +: SEL_W] = sel_q;
    assign next_flat[s*ST_W +: ST_W]  = next_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      halt_en  <= 1'b1;
      store_en <= 1'b0;
    end else if (act_we) begin
      halt_en  <= act_halt_en;
      store_en <= act_store_en;
    end
  end

endmodule

// File: rtl/dbg_trig_seq_pick.sv
module dbg_trig_seq_pick
  import dbg_trig_seq_pkg::*;
#(
  parameter int unsigned NUM_TRIG = 8,
  parameter int unsigned SEL_W    = 3
) (
  input  logic [NUM_TRIG-1:0]         trig_in,
  input  seq_st_t                     cur_st,
  input  logic [NUM_STATES*SEL_W-1:0] sel_flat,
  input  logic [NUM_STATES*ST_W-1:0]  next_flat,
  output logic                        fire,
  output seq_st_t                     next_st
);

  logic [SEL_W-1:0] sel_cur;

  always_comb begin
    sel_cur = sel_flat[cur_st*SEL_W +: SEL_W];
    next_st = next_flat[cur_st*ST_W +: ST_W];
    fire    = 1'b0;

    for (int unsigned i = 0; i < NUM_TRIG; i++) begin
      if (sel_cur == SEL_W'(i)) fire = trig_in[i];
    end
  end

endmodule

// File: rtl/dbg_trig_seq_fsm.sv
module dbg_trig_seq_fsm
  import dbg_trig_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clr,
  input  logic    fire,
  input  seq_st_t next_st,
  input  logic    halt_en,
  input  logic    store_en,
  output seq_st_t state_q,
  output logic    halt_q,
  output logic    store_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      halt_q  <= 1'b0;
      store_q <= 1'b0;
    end else begin
      halt_q  <= 1'b0;
      store_q <= 1'b0;
      if (clr) begin
        state_q <= ST_IDLE;
      end else if (state_q != ST_FINAL && fire) begin
        state_q <= next_st;
        if (next_st == ST_FINAL) begin
          halt_q  <= halt_en;
          store_q <= store_en;
        end
      end
    end
  end

  AST_FINAL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FINAL && !clr) |=> (state_q == ST_FINAL));                 // R7
  AST_HALT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |=> !halt_q);                                                      // R5
  AST_HALT_IN_FINAL: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> (state_q == ST_FINAL));                                        // R5
  AST_STORE_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    store_q |-> ((state_q == ST_FINAL) && ($past(state_q) != ST_FINAL)));     // R6
  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (state_q == ST_IDLE && !halt_q && !store_q));                     // R8
  AST_HOLD_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !fire) |=> $stable(state_q));                                    // R2

endmodule

// File: rtl/dbg_trig_seq.sv
module dbg_trig_seq
  import dbg_trig_seq_pkg::*;
#(
  parameter int unsigned NUM_TRIG = 8,
  localparam int unsigned SEL_W   = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_TRIG-1:0] trig_in,
  input  logic                rearm,
  input  logic                cfg_we,
  input  logic [1:0]          cfg_state,
  input  logic [SEL_W-1:0]    cfg_sel,
  input  logic [1:0]          cfg_next,
  input  logic                act_we,
  input  logic                act_halt_en,
  input  logic                act_store_en,
  output logic                halt_req,
  output logic                store_req,
  output logic [1:0]          seq_state
);

  logic [NUM_STATES*SEL_W-1:0] sel_flat;
  logic [NUM_STATES*ST_W-1:0]  next_flat;
  logic                        halt_en;
  logic                        store_en;
  logic                        fire;
  seq_st_t                     next_st;
  seq_st_t                     state_q;
  logic                        clr;

  assign clr = rearm | cfg_we | act_we;

  dbg_trig_seq_cfg #(.SEL_W(SEL_W)) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_state    (cfg_state),
    .cfg_sel      (cfg_sel),
    .cfg_next     (cfg_next),
    .act_we       (act_we),
    .act_halt_en  (act_halt_en),
    .act_store_en (act_store_en),
    .sel_flat     (sel_flat),
    .next_flat    (next_flat),
    .halt_en      (halt_en),
    .store_en     (store_en)
  );

  dbg_trig_seq_pick #(.NUM_TRIG(NUM_TRIG), .SEL_W(SEL_W)) u_pick (
    .trig_in   (trig_in),
    .cur_st    (state_q),
    .sel_flat  (sel_flat),
    .next_flat (next_flat),
    .fire      (fire),
    .next_st   (next_st)
  );

  dbg_trig_seq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .fire     (fire),
    .next_st  (next_st),
    .halt_en  (halt_en),
    .store_en (store_en),
    .state_q  (state_q),
    .halt_q   (halt_req),
    .store_q  (store_req)
  );

  assign seq_state = state_q;

  AST_PULSES_FINAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req || store_req) |-> (seq_state == 2'd3));                         // R6

endmodule

// File: tb/tb_dbg_trig_seq.sv
module tb_dbg_trig_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NT         = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT-1:0] trig_in = '0;
  logic          rearm = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_state = '0;
  logic [2:0]    cfg_sel = '0;
  logic [1:0]    cfg_next = '0;
  logic          act_we = 1'b0;
  logic          act_halt_en = 1'b0;
  logic          act_store_en = 1'b0;
  logic          halt_req;
  logic          store_req;
  logic [1:0]    seq_state;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [1:0] m_sel_next [4];
  logic [2:0] m_sel [4];
  logic       m_halt;
  logic       m_store;
  logic [1:0] m_st;

  logic [3:0] exp_q [$];
  string      tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_trig_seq #(.NUM_TRIG(NT)) dut (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .rearm(rearm),
    .cfg_we(cfg_we), .cfg_state(cfg_state), .cfg_sel(cfg_sel), .cfg_next(cfg_next),
    .act_we(act_we), .act_halt_en(act_halt_en), .act_store_en(act_store_en),
    .halt_req(halt_req), .store_req(store_req), .seq_state(seq_state)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Monitor: pops one expectation per edge, a quarter period after it.
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, "state", int'(seq_state), int'(e[1:0]));
      check(t, "halt",  int'(halt_req),  int'(e[2]));
      check(t, "store", int'(store_req), int'(e[3]));
    end
  end

  // Driver: applies one cycle of stimulus and pushes the predicted result.
  task automatic drive(input logic [NT-1:0] t, input logic ra,
                       input logic cwe, input logic [1:0] cs, input logic [2:0] csel,
                       input logic [1:0] cn, input logic awe, input logic ah,
                       input logic as_, input string tag);
    logic [1:0] nst;
    logic h, s;
    @(negedge clk);
    trig_in = t; rearm = ra; cfg_we = cwe; cfg_state = cs; cfg_sel = csel;
    cfg_next = cn; act_we = awe; act_halt_en = ah; act_store_en = as_;
    nst = m_st; h = 1'b0; s = 1'b0;
    if (ra || cwe || awe) nst = 2'd0;
    else if (m_st != 2'd3 && t[m_sel[m_st]]) begin
      nst = m_sel_next[m_st];
      if (nst == 2'd3) begin h = m_halt; s = m_store; end
    end
    m_st = nst;
    if (cwe) begin m_sel[cs] = csel; m_sel_next[cs] = cn; end
    if (awe) begin m_halt = ah; m_store = as_; end
    exp_q.push_back({s, h, nst});
    tag_q.push_back(tag);
  endtask

  task automatic trig(input logic [NT-1:0] t, input string tag);
    drive(t, 1'b0, 1'b0, 2'd0, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, tag);
  endtask
  task automatic do_rearm(input logic [NT-1:0] t, input string tag);
    drive(t, 1'b1, 1'b0, 2'd0, 3'd0, 2'd0, 1'b0, 1'b0, 1'b0, tag);
  endtask
  task automatic wr_entry(input logic [1:0] cs, input logic [2:0] csel,
                          input logic [1:0] cn, input string tag);
    drive('1, 1'b0, 1'b1, cs, csel, cn, 1'b0, 1'b0, 1'b0, tag);
  endtask
  task automatic wr_act(input logic ah, input logic as_, input string tag);
    drive('1, 1'b0, 1'b0, 2'd0, 3'd0, 2'd0, 1'b1, ah, as_, tag);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_sel[i] = 3'd0;
      m_sel_next[i] = (i == 3) ? 2'd3 : 2'(i + 1);
    end
    m_halt = 1'b1; m_store = 1'b0; m_st = 2'd0;

    // R1: reset state, with triggers active during reset
    trig_in = '1;
    repeat (3) @(negedge clk);
    check("R1", "state", int'(seq_state), 0);
    check("R1", "halt",  int'(halt_req), 0);
    check("R1", "store", int'(store_req), 0);
    trig_in = '0;
    rst_n = 1'b1;

    // R1 / R5: default chain on trigger 0, halt enabled, store disabled
    trig(8'h01, "R1");
    trig(8'h00, "R2");
    trig(8'h01, "R1");
    trig(8'h01, "R5");
    // R7: triggers ignored in the final state
    trig(8'hFF, "R7");
    trig(8'h01, "R7");
    // R8: rearm wins over an active trigger
    do_rearm(8'hFF, "R8");
    trig(8'h00, "R8");

    // R9: reprogram, writes return to state 0
    wr_act(1'b0, 1'b1, "R9");
    wr_entry(2'd0, 3'd2, 2'd1, "R9");
    wr_entry(2'd1, 3'd5, 2'd2, "R9");
    wr_entry(2'd2, 3'd7, 2'd3, "R9");
    // R3: unselected bits have no effect
    trig(8'hFB, "R3");
    trig(8'h00, "R2");
    trig(8'h04, "R2");
    trig(8'hDF, "R3");
    do_rearm(8'h00, "R8");
    // R4 / R6: all ones advance one step per clock, store only
    trig(8'hFF, "R4");
    trig(8'hFF, "R4");
    trig(8'hFF, "R6");
    trig(8'hFF, "R7");

    // R10: skip forward 0 -> 3 with both actions
    wr_act(1'b1, 1'b1, "R6");
    wr_entry(2'd0, 3'd4, 2'd3, "R10");
    trig(8'h10, "R10");
    trig(8'h00, "R7");

    // R10: backward loop 0 -> 1 -> 0
    wr_entry(2'd0, 3'd1, 2'd1, "R10");
    wr_entry(2'd1, 3'd3, 2'd0, "R10");
    trig(8'h02, "R10");
    trig(8'h08, "R10");
    trig(8'h02, "R10");
    // R9: a config write mid-sequence returns to 0 and applies next cycle
    wr_entry(2'd1, 3'd6, 2'd3, "R9");
    trig(8'h02, "R9");
    trig(8'h08, "R9");
    trig(8'h40, "R5");
    trig(8'h00, "R7");

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule